// File: doc/BRIEF.md
# Compare-Match Event Counter

This block is a counter with a programmable match value. Software configures it through a small synchronous register bus. In time-base mode the counter advances once for each cycle on which an external tick strobe is high. That strobe comes from a prescaler that sits outside this block. In pulse mode the counter advances once for each rising edge on one of four already-filtered input lines. The line is chosen by a select field, and an optional inversion lets falling edges be counted instead.

When an event carries the count past the match value, a sticky match flag is set. This is the moment the count would become match+1. In auto-reload operation the counter then returns to zero, which gives a period of match+1 events. In free-running operation it keeps counting and wraps only when it passes all-ones. The flag drives an interrupt line and a DMA request line, and each line has its own enable. Software clears the flag by writing a one to its bit.

The bus uses word addresses. Address 0 is control/status, address 1 is the match value, and address 2 is the live count, which is read-only. Read data is combinational from the address. A write takes effect at the clock edge on which the write strobe is high.

Top module: `lpt_cmp_timer`

## Requirements
- R1: After reset, the control word, the match value and the count all read 0, and irq_o and dma_req_o are low.
- R2: The control word bit layout is: bit0 run enable, bit1 mode (0 time base, 1 pulse), bit2 free-run, bit3 invert, bits5:4 line select, bit6 interrupt enable, bit7 match flag, bit8 DMA enable. Writable bits read back as written, and bits 31:9 read 0.
- R3: While run enable is 0, the count reads 0, the match flag reads 0, and ticks and pin edges have no effect.
- R4: In mode 0 with run enable 1, the count rises by one at each clock edge on which tick_i is high. The count is read at address 2.
- R5: In mode 1, the count rises by one for each rising edge of pins_i[n], where n is the line select code (0..3). tick_i and the unselected lines have no effect.
- R6: With invert set, the selected line is complemented before edge detection, so falling edges of the raw pin are counted.
- R7: An event taken while the count equals the match value sets the match flag. With free-run 0, the count becomes 0 on that same edge.
- R8: With free-run 1, the same event sets the flag and the count continues to match+1. The count wraps from all-ones to 0.
- R9: Writing control with bit7 = 1 clears the flag, and writing bit7 = 0 leaves it unchanged. A match on the same edge as a clear leaves the flag set.
- R10: irq_o equals flag AND interrupt enable, and dma_req_o equals flag AND DMA enable.
- R11: While run enable is 1, control writes leave mode, invert and line select unchanged. Enable, free-run and both request enables still take the written value.
- R12: The match value (address 1) can be written at any time. Writes to address 2 do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time-base strobe, one count per high cycle in mode 0 |
| pins_i | input | 4 | Filtered pulse input lines |
| bus_addr | input | 2 | Word address: 0 control, 1 match, 2 count |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |

## Verification
The bench targets the match boundary, the lock on configuration, and flag timing. A counter that matched one event early or late would give a reload period of match or match+2 instead of match+1. A counter that held match+1 instead of clearing would be caught at every match edge.

A match value of zero checks that each event re-asserts the flag while the count stays at zero. A clear issued on the same edge as a match checks that the set wins. A clear that won instead would drop the request for a full period.

Pulse mode is checked with pins held high across the enable write, which must not count as an edge. Activity on unselected lines must not count either. Free-running mode is taken through an all-ones wrap on a narrow counter, which exposes any saturation or reload in that mode.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  localparam int unsigned LPT_LINES  = 4;
  localparam int unsigned LPT_SEL_W  = $clog2(LPT_LINES);
  localparam int unsigned LPT_BUS_W  = 32;

  // control word bit positions (software decodes these)
  localparam int unsigned B_RUN   = 0;
  localparam int unsigned B_MODE  = 1;
  localparam int unsigned B_FREE  = 2;
  localparam int unsigned B_INV   = 3;
  localparam int unsigned B_SEL   = 4;
  localparam int unsigned B_IE    = 6;
  localparam int unsigned B_FLAG  = 7;
  localparam int unsigned B_DE    = 8;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_MATCH = 2'd1,
    A_COUNT = 2'd2,
    A_NONE  = 2'd3
  } lpt_addr_e;

  typedef struct packed {
    logic                 de;
    logic                 ie;
    logic [LPT_SEL_W-1:0] sel;
    logic                 inv;
    logic                 free;
    logic                 pulse_mode;
    logic                 run;
  } lpt_cfg_t;

  function automatic logic [LPT_BUS_W-1:0] pack_ctrl(lpt_cfg_t c, logic flag);
    logic [LPT_BUS_W-1:0] w;
    w = '0;
    w[B_RUN]  = c.run;
    w[B_MODE] = c.pulse_mode;
    w[B_FREE] = c.free;
    w[B_INV]  = c.inv;
    w[B_SEL +: LPT_SEL_W] = c.sel;
    w[B_IE]   = c.ie;
    w[B_FLAG] = flag;
    w[B_DE]   = c.de;
    return w;
  endfunction

endpackage

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           bus_addr,
  input  logic                 bus_we,
  input  logic [LPT_BUS_W-1:0] bus_wdata,
  output lpt_cfg_t             cfg_q,
  output logic [CNT_W-1:0]     match_q,
  output logic                 flag_clr
);

  logic wr_ctrl;
  logic wr_match;

  assign wr_ctrl  = bus_we && (lpt_addr_e'(bus_addr) == A_CTRL);
  assign wr_match = bus_we && (lpt_addr_e'(bus_addr) == A_MATCH);
  assign flag_clr = wr_ctrl && bus_wdata[B_FLAG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_ctrl) begin
      cfg_q.run  <= bus_wdata[B_RUN];
      cfg_q.free <= bus_wdata[B_FREE];
      cfg_q.ie   <= bus_wdata[B_IE];
      cfg_q.de   <= bus_wdata[B_DE];
      if (!cfg_q.run) begin
        cfg_q.pulse_mode <= bus_wdata[B_MODE];
        cfg_q.inv        <= bus_wdata[B_INV];
        cfg_q.sel        <= bus_wdata[B_SEL +: LPT_SEL_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= '0;
    else if (wr_match) match_q <= bus_wdata[CNT_W-1:0];
  end

  // R11
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.run && wr_ctrl) |=>
      ($stable(cfg_q.pulse_mode) && $stable(cfg_q.inv) && $stable(cfg_q.sel)));

endmodule

// File: rtl/lpt_evt.sv
module lpt_evt
  import lpt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  lpt_cfg_t             cfg,
  input  logic                 tick_i,
  input  logic [LPT_LINES-1:0] pins_i,
  output logic                 evt
);

  logic lvl;
  logic lvl_q;
  logic rise;

  assign lvl  = pins_i[cfg.sel] ^ cfg.inv;
  assign rise = lvl && !lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  always_comb begin
    if (!cfg.run)            evt = 1'b0;
    else if (cfg.pulse_mode) evt = rise;
    else                     evt = tick_i;
  end

  // R5
  pulse_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.run && cfg.pulse_mode && evt) |-> !lvl_q);

endmodule

// File: rtl/lpt_cnt.sv
module lpt_cnt
  import lpt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             free,
  input  logic             evt,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q,
  output logic             hit
);

  function automatic logic [CNT_W-1:0] bump(logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction

  assign hit = evt && (cnt_q == match_val);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
    end else if (hit && !free) begin
      cnt_q <= '0;
    end else if (evt) begin
      cnt_q <= bump(cnt_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) flag_q <= 1'b0;
    else if (hit)       flag_q <= 1'b1;
    else if (flag_clr)  flag_q <= 1'b0;
  end

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0 && !flag_q));
  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hit && !free) |=> (cnt_q == '0 && flag_q));
  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && evt && !(hit && !free)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !evt) |=> $stable(cnt_q));
  // R9
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hit));

endmodule

// File: rtl/lpt_cmp_timer.sv
module lpt_cmp_timer
  import lpt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic [3:0]  pins_i,
  input  logic [1:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        dma_req_o
);

  lpt_cfg_t         cfg;
  logic [CNT_W-1:0] match_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_clr;
  logic             flag_q;
  logic             evt;
  logic             hit;

  lpt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .cfg_q(cfg), .match_q(match_q), .flag_clr(flag_clr)
  );

  lpt_evt u_evt (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .tick_i(tick_i),
    .pins_i(pins_i), .evt(evt)
  );

  lpt_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(cfg.run), .free(cfg.free), .evt(evt),
    .flag_clr(flag_clr), .match_val(match_q), .cnt_q(cnt_q),
    .flag_q(flag_q), .hit(hit)
  );

  always_comb begin
    case (lpt_addr_e'(bus_addr))
      A_CTRL:  bus_rdata = pack_ctrl(cfg, flag_q);
      A_MATCH: bus_rdata = 32'(match_q);
      A_COUNT: bus_rdata = 32'(cnt_q);
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o     = flag_q && cfg.ie;
  assign dma_req_o = flag_q && cfg.de;

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(hit) || $rose(cfg.ie)));
  // R10
  dma_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req_o) |-> ($past(hit) || $rose(cfg.de)));

endmodule

// File: tb/sim_lpt_cmp_timer.sv
module sim_lpt_cmp_timer;

  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int unsigned MASK = (1 << W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [3:0]  pins_i = 4'h0;
  logic [1:0]  bus_addr = 2'd2;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, dma_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  lpt_cmp_timer #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pins_i(pins_i),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  bit m_run, m_mode, m_free, m_inv, m_ie, m_de, m_flag, m_prev;
  int unsigned m_sel, m_match, m_cnt;

  function automatic int unsigned ctrl_word(bit run, bit mode, bit free, bit inv,
                                            int unsigned sel, bit ie, bit clr, bit de);
    return run | (mode << 1) | (free << 2) | (inv << 3) | ((sel & 3) << 4)
         | (ie << 6) | (clr << 7) | (de << 8);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_run, m_mode, m_free, m_inv, m_ie, m_de, m_flag, m_prev} = '0;
      m_sel = 0; m_match = 0; m_cnt = 0;
    end else begin
      bit lvl, ev, nflag;
      int unsigned ncnt;
      lvl = pins_i[m_sel] ^ m_inv;
      ev = m_run && (m_mode ? (lvl && !m_prev) : tick_i);
      ncnt = m_cnt; nflag = m_flag;
      if (!m_run) begin
        ncnt = 0; nflag = 0;
      end else begin
        if (bus_we && bus_addr == 2'd0 && bus_wdata[7]) nflag = 0;
        if (ev) begin
          if (m_cnt == m_match) begin
            nflag = 1;
            ncnt = m_free ? ((m_cnt + 1) & MASK) : 0;
          end else begin
            ncnt = (m_cnt + 1) & MASK;
          end
        end
      end
      m_prev = lvl;
      if (bus_we && bus_addr == 2'd0) begin
        if (!m_run) begin
          m_mode = bus_wdata[1]; m_inv = bus_wdata[3]; m_sel = bus_wdata[5:4];
        end
        m_run = bus_wdata[0]; m_free = bus_wdata[2];
        m_ie = bus_wdata[6]; m_de = bus_wdata[8];
      end
      if (bus_we && bus_addr == 2'd1) m_match = bus_wdata & MASK;
      m_cnt = ncnt; m_flag = nflag;
    end
  end

  task automatic check(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int unsigned exp;
      string tag;
      case (bus_addr)
        2'd0: begin tag = "R2"; exp = ctrl_word(m_run, m_mode, m_free, m_inv, m_sel, m_ie, m_flag, m_de); end
        2'd1: begin tag = "R12"; exp = m_match; end
        2'd2: begin tag = "R4"; exp = m_cnt; end
        default: begin tag = "R2"; exp = 0; end
      endcase
      check(tag, bus_rdata, exp);
      check("R10", irq_o, m_flag & m_ie);
      check("R10", dma_req_o, m_flag & m_de);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(int unsigned a, int unsigned d);
    bus_addr = a[1:0]; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0; bus_addr = 2'd2;
  endtask

  task automatic rd(int unsigned a, output int unsigned d);
    bus_addr = a[1:0]; #1; d = bus_rdata; bus_addr = 2'd2;
  endtask

  task automatic ticks(int n);
    tick_i = 1'b1;
    for (int i = 0; i < n; i++) step();
    tick_i = 1'b0;
  endtask

  task automatic pulse(int line);
    pins_i[line] = ~pins_i[line]; step();
    pins_i[line] = ~pins_i[line]; step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned v;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    rd(0, v); check("R1", v, 0);
    rd(1, v); check("R1", v, 0);
    rd(2, v); check("R1", v, 0);
    check("R1", irq_o, 0);
    // R3 disabled: ticks ignored
    ticks(5);
    rd(2, v); check("R3", v, 0);
    // R4 / R7 time-base with reload
    wr(1, 5);
    wr(0, ctrl_word(1, 0, 0, 0, 0, 1, 0, 1));
    rd(0, v); check("R2", v, 32'h141);
    ticks(3);
    rd(2, v); check("R4", v, 3);
    ticks(2);
    rd(2, v); check("R4", v, 5);
    check("R7", irq_o, 0);
    ticks(1);
    rd(2, v); check("R7", v, 0);
    check("R7", irq_o, 1);
    check("R10", dma_req_o, 1);
    // R9 write-one-to-clear
    wr(0, ctrl_word(1, 0, 0, 0, 0, 1, 0, 1));
    check("R9", irq_o, 1);
    wr(0, ctrl_word(1, 0, 0, 0, 0, 1, 1, 1));
    check("R9", irq_o, 0);
    // R10 enables gate the lines
    wr(1, 0);
    ticks(1);
    wr(0, ctrl_word(1, 0, 0, 0, 0, 0, 0, 1));
    check("R10", irq_o, 0);
    check("R10", dma_req_o, 1);
    rd(0, v); check("R9", (v >> 7) & 1, 1);
    // R9 set wins over same-edge clear; R7 match value zero keeps count at zero
    tick_i = 1'b1;
    wr(0, ctrl_word(1, 0, 0, 0, 0, 1, 1, 1));
    tick_i = 1'b0;
    check("R9", irq_o, 1);
    rd(2, v); check("R7", v, 0);
    // R11 lock while running
    wr(0, ctrl_word(1, 1, 0, 1, 3, 1, 1, 1));
    rd(0, v); check("R11", v & 32'h3A, 0);
    // R3 disable clears
    wr(0, 0);
    step();
    rd(0, v); check("R3", v, 0);
    // R5 pulse mode on line 2, pins already high across enable
    wr(1, 100);
    pins_i = 4'hF;
    wr(0, ctrl_word(1, 1, 0, 0, 2, 0, 0, 0));
    step();
    rd(2, v); check("R5", v, 0);
    pins_i = 4'h0; step();
    pulse(2); pulse(2); pulse(2);
    pulse(0); pulse(3);
    ticks(4);
    rd(2, v); check("R5", v, 3);
    // R6 inverted line 1: falling edges counted
    wr(0, 0);
    pins_i = 4'h2;
    wr(0, ctrl_word(1, 1, 0, 1, 1, 0, 0, 0));
    step();
    pins_i[1] = 1'b0; step();
    step();
    rd(2, v); check("R6", v, 1);
    pins_i[1] = 1'b1; step();
    rd(2, v); check("R6", v, 1);
    pulse(1);
    rd(2, v); check("R6", v, 2);
    // R8 free-run through match and wrap
    wr(0, 0);
    wr(1, 10);
    wr(0, ctrl_word(1, 0, 1, 0, 0, 1, 0, 0));
    ticks(11);
    rd(2, v); check("R8", v, 11);
    check("R8", irq_o, 1);
    ticks(int'(MASK) - 11);
    rd(2, v); check("R8", v, MASK);
    ticks(1);
    rd(2, v); check("R8", v, 0);
    // R12 count is read-only, match writable while running
    ticks(3);
    wr(2, 77);
    rd(2, v); check("R12", v, 3);
    wr(1, 9);
    rd(1, v); check("R12", v, 9);
    step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule